// File: doc/BRIEF.md
# PHY Basic Status Register

This block holds the basic status word of an Ethernet PHY management register space. The word mixes three kinds of bit. Capability bits are fixed, and some of them follow the media mode (twisted-pair or fiber). A live auto-negotiation-complete flag is set by a done pulse from the negotiation engine. A sticky remote-fault flag latches on either of two sources: the link partner's advertised remote-fault bit, or a far-end-fault detect pulse.

The management transport presents a read strobe together with a register address. When the address matches the status register, the assembled word is captured into a registered read-data output. The same read clears the sticky remote-fault flag. The captured word carries the flag's value from before the clear, so the host sees each latched fault exactly once. Reads to other addresses leave both the output and the flag untouched.

Top module: `pbsr_top`

## Requirements
- R1: After synchronous reset, rd_data is 0x0000, and the remote-fault and negotiation-complete state are both clear.
- R2: Bit 11 (10 Mb/s half-duplex capable) reads 1 when fiber_mode is 0 and reads 0 when fiber_mode is 1.
- R3: Bits 15:12, bit 10 (100Base-T2 capable), bits 9:7 and bits 2:0 always read 0.
- R4: Bit 6 (management preamble suppression capable) and bit 3 (auto-negotiation capable) always read 1.
- R5: Bit 5 reads 1 once an_done has pulsed while an_enable is 1. The flag clears in the cycle after an_enable goes to 0.
- R6: Bit 5 reads 0 whenever fiber_mode is 1, even if negotiation has completed.
- R7: Bit 4 (remote fault) becomes 1 in the cycle after lp_rf or fef_detect is 1, and it stays 1 until a status read.
- R8: A status read returns bit 4 as it was before the read and clears the flag. A second read returns bit 4 as 0 if no new event has arrived.
- R9: A fault event in the same cycle as a clearing read leaves the flag set, so the next read returns bit 4 as 1.
- R10: A read strobe whose address differs from STAT_ADDR (default 1) leaves rd_data unchanged and does not clear the fault flag.
- R11: rd_data is updated on the clock edge that samples a matching read strobe. The new value is visible from then until the next matching read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fiber_mode | input | 1 | 1 selects fiber media, 0 selects twisted pair |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_done | input | 1 | One-cycle pulse when negotiation completes |
| lp_rf | input | 1 | Link partner's advertised remote-fault bit |
| fef_detect | input | 1 | Far-end-fault indication pulse |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register address of the read |
| rd_data | output | 16 | Registered read data |

## Verification
Every read result is due one clock edge after the strobe is sampled. The bench drives its inputs at the falling edge and registers a "due" flag at the rising edge. It then compares rd_data against the front of the expected queue at the following falling edge. Flag effects (fault latch, negotiation flag) become visible one edge after their input. The reference model updates its state after it computes each cycle's expected word, which matches that one-cycle lag. The read-and-event collision and the non-matching-address case go through the same queue, so any slip of a cycle shows up as a data mismatch.

// File: rtl/pbsr_pkg.sv
package pbsr_pkg;
  localparam int WORD_W      = 16;
  localparam int BIT_HD10    = 11;
  localparam int BIT_T2      = 10;
  localparam int BIT_PRE_SUP = 6;
  localparam int BIT_ANC     = 5;
  localparam int BIT_RFLT    = 4;
  localparam int BIT_AN_CAP  = 3;

  typedef struct packed {
    logic hd10;
    logic t2;
    logic pre_sup;
    logic an_cap;
  } cap_t;
endpackage

// File: rtl/pbsr_cap_map.sv
module pbsr_cap_map
  import pbsr_pkg::*;
(
  input  logic fiber_mode,
  output cap_t caps
);
  always_comb begin
    caps.hd10    = ~fiber_mode;
    caps.t2      = 1'b0;
    caps.pre_sup = 1'b1;
    caps.an_cap  = 1'b1;
  end
endmodule

// File: rtl/pbsr_fault_latch.sv
module pbsr_fault_latch #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic               flag
);
  logic any_evt;
  always_comb any_evt = |evt;

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (any_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> flag);
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  p_fault_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !any_evt) |=> !flag);
endmodule

// File: rtl/pbsr_anc_track.sv
module pbsr_anc_track (
  input  logic clk,
  input  logic rst,
  input  logic an_enable,
  input  logic an_done,
  output logic done_q
);
  always_ff @(posedge clk) begin
    if (rst || !an_enable) done_q <= 1'b0;
    else if (an_done)      done_q <= 1'b1;
  end

  p_anc_drop_r5: assert property (@(posedge clk) disable iff (rst)
    !an_enable |=> !done_q);
  p_anc_set_r5: assert property (@(posedge clk) disable iff (rst)
    (an_enable && an_done) |=> done_q);
endmodule

// File: rtl/pbsr_top.sv
module pbsr_top
  import pbsr_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fiber_mode,
  input  logic              an_enable,
  input  logic              an_done,
  input  logic              lp_rf,
  input  logic              fef_detect,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_ADDR);

  cap_t              caps;
  logic              rd_hit;
  logic              fault_q;
  logic              anc_q;
  logic [WORD_W-1:0] word;

  always_comb rd_hit = rd_en && (rd_addr == HIT_ADDR);

  pbsr_cap_map u_cap (
    .fiber_mode (fiber_mode),
    .caps       (caps)
  );

  pbsr_fault_latch #(.NUM_SRC(2)) u_fault (
    .clk  (clk),
    .rst  (rst),
    .evt  ({fef_detect, lp_rf}),
    .clr  (rd_hit),
    .flag (fault_q)
  );

  pbsr_anc_track u_anc (
    .clk       (clk),
    .rst       (rst),
    .an_enable (an_enable),
    .an_done   (an_done),
    .done_q    (anc_q)
  );

  always_comb begin
    word              = '0;
    word[BIT_HD10]    = caps.hd10;
    word[BIT_T2]      = caps.t2;
    word[BIT_PRE_SUP] = caps.pre_sup;
    word[BIT_ANC]     = anc_q & ~fiber_mode;
    word[BIT_RFLT]    = fault_q;
    word[BIT_AN_CAP]  = caps.an_cap;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= word;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(rd_data));
  p_fiber_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && fiber_mode) |=> (!rd_data[BIT_ANC] && !rd_data[BIT_HD10]));
  p_caps_r4: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data[BIT_PRE_SUP] && rd_data[BIT_AN_CAP]));
  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data[15:12] == 4'd0 && rd_data[10:7] == 4'd0 && rd_data[2:0] == 3'd0));
  p_fault_seen_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && fault_q) |=> rd_data[BIT_RFLT]);
endmodule

// File: tb/pbsr_top_tb.sv
module pbsr_top_tb;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] SA = 5'd1;

  logic clk = 0, rst = 1;
  logic fiber_mode = 0, an_enable = 0, an_done = 0, lp_rf = 0, fef_detect = 0, rd_en = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  pbsr_top #(.ADDR_W(ADDR_W), .STAT_ADDR(1)) u_dut (
    .clk(clk), .rst(rst), .fiber_mode(fiber_mode), .an_enable(an_enable),
    .an_done(an_done), .lp_rf(lp_rf), .fef_detect(fef_detect),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  typedef struct { logic [15:0] data; string tag; } item_t;
  item_t q[$];
  int checks = 0, failures = 0;
  logic m_fault = 0, m_anc = 0;
  logic [15:0] m_last = 16'h0;
  logic due = 0;
  logic done_flag = 0;

  always @(posedge clk) due <= !rst && rd_en;

  always @(negedge clk) begin
    if (due && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd_data !== it.data) begin
        failures++;
        $display("FAIL %s: rd_data=%h expected=%h", it.tag, rd_data, it.data);
      end
    end
  end

  task automatic cyc(input logic fib, input logic en, input logic dn,
                     input logic rf, input logic fe, input logic rd,
                     input logic [ADDR_W-1:0] ad, input string tag);
    logic [15:0] w;
    logic hit;
    @(negedge clk);
    fiber_mode = fib; an_enable = en; an_done = dn; lp_rf = rf;
    fef_detect = fe; rd_en = rd; rd_addr = ad;
    hit = rd && (ad == SA);
    w = 16'h0;
    w[11] = !fib; w[6] = 1'b1; w[3] = 1'b1;
    w[5] = m_anc & !fib; w[4] = m_fault;
    if (hit) m_last = w;
    if (rd) begin
      item_t it;
      it.data = m_last; it.tag = tag;
      q.push_back(it);
    end
    m_fault = (rf | fe) | (m_fault & !hit);
    m_anc = !en ? 1'b0 : (dn ? 1'b1 : m_anc);
  endtask

  task automatic idle(input logic fib, input logic en);
    cyc(fib, en, 0, 0, 0, 0, '0, "idle");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        checks++;
        if (rd_data !== 16'h0) begin
          failures++; $display("FAIL R1: rd_data=%h expected=0000", rd_data);
        end
        cyc(0, 0, 0, 0, 0, 1, SA, "R1 R2 R3 R4 twisted-pair base");
        cyc(1, 0, 0, 0, 0, 1, SA, "R2 R3 R4 fiber base");
        cyc(0, 1, 0, 0, 0, 1, SA, "R5 enabled not done");
        cyc(0, 1, 1, 0, 0, 0, '0, "R5 done pulse");
        cyc(0, 1, 0, 0, 0, 1, SA, "R5 complete visible");
        cyc(1, 1, 0, 0, 0, 1, SA, "R6 fiber masks complete");
        cyc(0, 1, 0, 0, 0, 1, SA, "R5 back to twisted pair");
        cyc(0, 0, 0, 0, 0, 0, '0, "R5 disable");
        cyc(0, 1, 0, 0, 0, 1, SA, "R5 cleared after disable");
        cyc(0, 1, 0, 1, 0, 0, '0, "R7 lp_rf event");
        idle(0, 1); idle(0, 1);
        cyc(0, 1, 0, 0, 0, 1, 5'd4, "R10 other address hold");
        cyc(0, 1, 0, 0, 0, 1, SA, "R7 R8 latched fault seen");
        cyc(0, 1, 0, 0, 0, 1, SA, "R8 cleared after read");
        cyc(0, 1, 0, 0, 1, 0, '0, "R7 far-end event");
        cyc(0, 1, 0, 0, 1, 1, SA, "R9 read with event");
        cyc(0, 1, 0, 0, 0, 1, SA, "R9 event kept");
        cyc(0, 1, 0, 0, 0, 1, SA, "R8 clear after collision");
        cyc(1, 1, 0, 0, 1, 0, '0, "R7 fault in fiber");
        cyc(1, 1, 0, 0, 0, 1, 5'd0, "R10 addr 0 no clear");
        cyc(1, 1, 0, 0, 0, 1, SA, "R11 R2 fiber fault read");
        cyc(0, 1, 1, 0, 0, 1, SA, "R11 done with read");
        cyc(0, 1, 0, 0, 0, 1, SA, "R11 R5 after done");
        idle(0, 1); idle(0, 1);
        done_flag = 1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done_flag) begin
          checks++; failures++;
          $display("FAIL watchdog: done=0 expected=1");
        end
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule